// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Register

This block holds the 64-bit control and identification word of a virtual interrupt CPU interface, together with the two 3-bit binary point registers that set the preemption grouping. Software reaches all three through one register port. The port has a select, a read/write flag and a secure qualifier. Reads are combinational from the select. Writes take effect at the rising clock edge on which `acc_en` and `acc_wr` are both high.

The identification fields in the control word are fixed by module parameters. Elaboration stops if a parameter value is illegal. The block drives these fields out to the rest of the interface, along with two signals. The first says whether an end-of-interrupt write should also deactivate. The second carries the common binary point setting. While the common bit is set, group-1 binary point accesses alias onto the group-0 register. A secure access and a non-secure access see different behaviour.

Top module: `virq_ctl_reg`

## Requirements
- R1: Select code 0 reads the control word, 1 reads binary point 0 and 2 reads binary point 1. In the control word, bits 63:20, 17:16 and 7:2 always read zero. Binary point reads are zero-extended to 64 bits. Select code 3 reads zero, and a write to it changes nothing.
- R2: Control bits 19 (extended ID range), 18 (range selector), 15 (affinity-3 valid) and 14 (local SEI) equal their parameters. Writes to these bits have no effect.
- R3: Control bits 13:11 hold the identifier-width code from a parameter: 000 for 16 bits, 001 for 24 bits. Any other code is rejected at elaboration. Writes have no effect.
- R4: Control bits 10:8 hold the number of priority bits minus one, from a parameter. Only 100 to 110 are accepted. Writes have no effect.
- R5: Control bit 1 is the EOI mode and can be written. `eoi_deact` is 1 exactly when this bit is 0.
- R6: Control bit 0 is the common binary point bit and can be written. At 0, binary point 1 is an independent register that any access reads and writes directly.
- R7: With bit 0 at 1, a non-secure read of binary point 1 returns binary point 0 plus one, saturated at 3'b111.
- R8: With bit 0 at 1, a non-secure write to binary point 1 leaves both binary point registers unchanged.
- R9: With bit 0 at 1, a secure read of binary point 1 returns binary point 0, and a secure write to binary point 1 updates binary point 0.
- R10: After reset, control bits 1 and 0 are 0, and binary point 0 and binary point 1 hold their reset parameters (defaults 2 and 3).
- R11: A binary point write stores `acc_wdata[2:0]` and ignores the upper data bits. Binary point 0 accesses do not depend on the common bit or on security.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Register select: 0 control, 1 binary point 0, 2 binary point 1 |
| acc_secure | input | 1 | Access is secure |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for the current select |
| feat_ext_range | output | 1 | Extended interrupt-ID range supported |
| feat_range_sel | output | 1 | Range selector supported |
| feat_aff3 | output | 1 | Nonzero affinity 3 supported |
| feat_sei | output | 1 | Local SEI generation supported |
| feat_id_code | output | 3 | Identifier-width code |
| feat_pri_code | output | 3 | Priority bits minus one |
| eoi_deact | output | 1 | End-of-interrupt write also deactivates |
| cbp_on | output | 1 | Common binary point bit |

## Verification
The assertions assume that `acc_sel`, `acc_wr` and `acc_secure` are stable, known values whenever `acc_en` is high. They also assume that each write is one clean single-cycle pulse, so that a `$past` of the write data names the value that was stored. The stimulus changes every input only at the falling edge and holds it for a full cycle, so these assumptions hold. It also drops `acc_en` between accesses, which keeps back-to-back writes from blurring which write a check refers to.

// File: rtl/virq_ctl_pkg.sv
package virq_ctl_pkg;
   localparam int unsigned CTL_W  = 64;
   localparam int unsigned BP_W   = 3;
   localparam int unsigned POS_EXT  = 19;
   localparam int unsigned POS_RSEL = 18;
   localparam int unsigned POS_AFF3 = 15;
   localparam int unsigned POS_SEI  = 14;
   localparam int unsigned POS_ID   = 11;
   localparam int unsigned POS_PRI  = 8;
   localparam int unsigned POS_EOI  = 1;
   localparam int unsigned POS_CBP  = 0;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_BP0  = 2'd1,
      SEL_BP1  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic logic [BP_W-1:0] bp_sat_inc(input logic [BP_W-1:0] v);
      return (&v) ? v : v + 1'b1;
   endfunction
endpackage

// File: rtl/virq_ctl_bits.sv
module virq_ctl_bits
   import virq_ctl_pkg::*;
#(
   parameter bit       EXT_RANGE = 1'b1,
   parameter bit       RANGE_SEL = 1'b0,
   parameter bit       AFF3_OK   = 1'b1,
   parameter bit       SEI_LOCAL = 1'b0,
   parameter bit [2:0] ID_CODE   = 3'b001,
   parameter bit [2:0] PRI_CODE  = 3'b100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output logic             eoi_mode,
   output logic             cbp,
   output logic [CTL_W-1:0] word
);
   generate
      if (ID_CODE > 3'b001) begin : g_bad_id
         $error("virq_ctl_bits: ID_CODE must be 0 or 1");
      end
      if (PRI_CODE < 3'b100 || PRI_CODE > 3'b110) begin : g_bad_pri
         $error("virq_ctl_bits: PRI_CODE must be 4..6");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoi_mode <= 1'b0;
         cbp      <= 1'b0;
      end else if (wr_en) begin
         eoi_mode <= wdata[POS_EOI];
         cbp      <= wdata[POS_CBP];
      end
   end

   always_comb begin
      word                    = '0;
      word[POS_EXT]           = EXT_RANGE;
      word[POS_RSEL]          = RANGE_SEL;
      word[POS_AFF3]          = AFF3_OK;
      word[POS_SEI]           = SEI_LOCAL;
      word[POS_ID +: 3]       = ID_CODE;
      word[POS_PRI +: 3]      = PRI_CODE;
      word[POS_EOI]           = eoi_mode;
      word[POS_CBP]           = cbp;
   end

   // R5: a control write lands in the EOI mode bit on the next edge
   a_r5_eoi_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> eoi_mode == $past(wdata[POS_EOI]));
   // R6: common bit changes only through a control write
   a_r6_cbp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cbp));
endmodule

// File: rtl/virq_bp_bank.sv
module virq_bp_bank
   import virq_ctl_pkg::*;
#(
   parameter int unsigned  W       = BP_W,
   parameter bit [W-1:0]   BP0_RST = 2,
   parameter bit [W-1:0]   BP1_RST = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr0,
   input  logic         wr1,
   input  logic         secure,
   input  logic         cbp,
   input  logic [W-1:0] wval,
   output logic [W-1:0] rd0,
   output logic [W-1:0] rd1
);
   generate
      if (W < 1 || W > 8) begin : g_bad_w
         $error("virq_bp_bank: W must be 1..8");
      end
   endgenerate

   logic [W-1:0] bp0_q, bp1_q;
   logic         w1_to0, w1_own;

   assign w1_to0 = wr1 && cbp && secure;
   assign w1_own = wr1 && !cbp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp0_q <= BP0_RST;
         bp1_q <= BP1_RST;
      end else begin
         if (wr0 || w1_to0) bp0_q <= wval;
         if (w1_own)        bp1_q <= wval;
      end
   end

   always_comb begin
      rd0 = bp0_q;
      if (!cbp)        rd1 = bp1_q;
      else if (secure) rd1 = bp0_q;
      else             rd1 = (&bp0_q) ? bp0_q : bp0_q + 1'b1;
   end

   // R7: aliased non-secure read never falls below the group-0 value
   a_r7_ns_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cbp && !secure) |-> (rd1 >= rd0 && rd1 != '0));
   // R8: aliased non-secure write touches neither register
   a_r8_ns_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !wr0 && cbp && !secure) |=> ($stable(rd0) && $stable(bp1_q)));
   // R9: aliased secure write lands in group 0
   a_r9_sec_write_bp0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && cbp && secure) |=> rd0 == $past(wval));
   // R11: group-0 write stores the value regardless of mode
   a_r11_bp0_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> rd0 == $past(wval));
endmodule

// File: rtl/virq_rd_mux.sv
module virq_rd_mux
   import virq_ctl_pkg::*;
#(
   parameter int unsigned W = BP_W
) (
   input  logic [1:0]       sel,
   input  logic [CTL_W-1:0] ctl_word,
   input  logic [W-1:0]     bp0,
   input  logic [W-1:0]     bp1,
   output logic [CTL_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      unique case (reg_sel_e'(sel))
         SEL_CTL:  rdata = ctl_word;
         SEL_BP0:  rdata[W-1:0] = bp0;
         SEL_BP1:  rdata[W-1:0] = bp1;
         SEL_NONE: rdata = '0;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/virq_ctl_reg.sv
module virq_ctl_reg
   import virq_ctl_pkg::*;
#(
   parameter bit         EXT_RANGE = 1'b1,
   parameter bit         RANGE_SEL = 1'b0,
   parameter bit         AFF3_OK   = 1'b1,
   parameter bit         SEI_LOCAL = 1'b0,
   parameter bit [2:0]   ID_CODE   = 3'b001,
   parameter bit [2:0]   PRI_CODE  = 3'b100,
   parameter bit [2:0]   BP0_RST   = 3'd2,
   parameter bit [2:0]   BP1_RST   = 3'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_sel,
   input  logic              acc_secure,
   input  logic [63:0]       acc_wdata,
   output logic [63:0]       acc_rdata,
   output logic              feat_ext_range,
   output logic              feat_range_sel,
   output logic              feat_aff3,
   output logic              feat_sei,
   output logic [2:0]        feat_id_code,
   output logic [2:0]        feat_pri_code,
   output logic              eoi_deact,
   output logic              cbp_on
);
   localparam int unsigned RSV_HI_W = CTL_W - 20;

   logic             wr_any, wr_ctl, wr_bp0, wr_bp1;
   logic             eoi_mode, cbp;
   logic [CTL_W-1:0] ctl_word;
   logic [BP_W-1:0]  bp0_rd, bp1_rd;

   assign wr_any = acc_en && acc_wr;
   assign wr_ctl = wr_any && (reg_sel_e'(acc_sel) == SEL_CTL);
   assign wr_bp0 = wr_any && (reg_sel_e'(acc_sel) == SEL_BP0);
   assign wr_bp1 = wr_any && (reg_sel_e'(acc_sel) == SEL_BP1);

   virq_ctl_bits #(
      .EXT_RANGE(EXT_RANGE), .RANGE_SEL(RANGE_SEL), .AFF3_OK(AFF3_OK),
      .SEI_LOCAL(SEI_LOCAL), .ID_CODE(ID_CODE), .PRI_CODE(PRI_CODE)
   ) u_bits (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .wdata(acc_wdata),
      .eoi_mode(eoi_mode), .cbp(cbp), .word(ctl_word)
   );

   virq_bp_bank #(.W(BP_W), .BP0_RST(BP0_RST), .BP1_RST(BP1_RST)) u_bp (
      .clk(clk), .rst_n(rst_n), .wr0(wr_bp0), .wr1(wr_bp1),
      .secure(acc_secure), .cbp(cbp), .wval(acc_wdata[BP_W-1:0]),
      .rd0(bp0_rd), .rd1(bp1_rd)
   );

   virq_rd_mux #(.W(BP_W)) u_mux (
      .sel(acc_sel), .ctl_word(ctl_word), .bp0(bp0_rd), .bp1(bp1_rd),
      .rdata(acc_rdata)
   );

   assign feat_ext_range = ctl_word[POS_EXT];
   assign feat_range_sel = ctl_word[POS_RSEL];
   assign feat_aff3      = ctl_word[POS_AFF3];
   assign feat_sei       = ctl_word[POS_SEI];
   assign feat_id_code   = ctl_word[POS_ID +: 3];
   assign feat_pri_code  = ctl_word[POS_PRI +: 3];
   assign eoi_deact      = !eoi_mode;
   assign cbp_on         = cbp;

   // R1: reserved control bits and upper binary point bits read zero
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel == 2'd0) |-> (acc_rdata[CTL_W-1:20] == '0 && acc_rdata[17:16] == '0
                             && acc_rdata[7:2] == '0 && RSV_HI_W > 0));
   a_r1_bp_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel[0] ^ acc_sel[1]) |-> acc_rdata[CTL_W-1:BP_W] == '0);
   // R2: feature outputs never move
   a_r2_feature_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($stable(feat_ext_range) && $stable(feat_range_sel)
                && $stable(feat_aff3) && $stable(feat_sei)));
   // R3 / R4: code fields hold legal values
   a_r3_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
      feat_id_code[2:1] == 2'b00);
   a_r4_pri_legal: assert property (@(posedge clk) disable iff (!rst_n)
      feat_pri_code[2] && feat_pri_code[1:0] != 2'b11);
   // R5: EOI deactivate output follows the last control write
   a_r5_deact_out: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> eoi_deact == !$past(acc_wdata[1]));
endmodule

// File: tb/sim_virq_ctl_reg.sv
`timescale 1ns/100ps
module sim_virq_ctl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, acc_secure = 1'b0;
   logic [1:0]  acc_sel = 2'd0;
   logic [63:0] acc_wdata = '0;
   logic [63:0] acc_rdata;
   logic        feat_ext_range, feat_range_sel, feat_aff3, feat_sei;
   logic [2:0]  feat_id_code, feat_pri_code;
   logic        eoi_deact, cbp_on;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // default parameters: EXT=1 RSEL=0 AFF3=1 SEI=0 ID=1 PRI=4 BP0=2 BP1=3
   localparam logic [63:0] CTL_BASE = (64'd1 << 19) | (64'd1 << 15)
                                    | (64'd1 << 11) | (64'd4 << 8);

   virq_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_sel(acc_sel), .acc_secure(acc_secure), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .feat_ext_range(feat_ext_range),
      .feat_range_sel(feat_range_sel), .feat_aff3(feat_aff3), .feat_sei(feat_sei),
      .feat_id_code(feat_id_code), .feat_pri_code(feat_pri_code),
      .eoi_deact(eoi_deact), .cbp_on(cbp_on)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic sec, input logic [63:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1; acc_sel = sel; acc_secure = sec; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic sec, output logic [63:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_sel = sel; acc_secure = sec;
      #1 d = acc_rdata;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   function automatic logic [63:0] sat1(input int v);
      return (v >= 7) ? 64'd7 : 64'(v + 1);
   endfunction

   initial begin
      logic [63:0] r;
      int last_bp1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state, R1 map
      rd(2'd0, 1'b0, r); chk("R10 ctl reset", r, CTL_BASE);
      rd(2'd1, 1'b0, r); chk("R10 bp0 reset", r, 64'd2);
      rd(2'd2, 1'b0, r); chk("R10 bp1 reset", r, 64'd3);
      chk("R10 eoi_deact reset", 64'(eoi_deact), 64'd1);
      rd(2'd3, 1'b1, r); chk("R1 select 3 reads zero", r, 64'd0);

      // R2 R3 R4 feature exports
      chk("R2 ext", 64'(feat_ext_range), 64'd1);
      chk("R2 rsel", 64'(feat_range_sel), 64'd0);
      chk("R2 aff3", 64'(feat_aff3), 64'd1);
      chk("R2 sei", 64'(feat_sei), 64'd0);
      chk("R3 id code", 64'(feat_id_code), 64'd1);
      chk("R4 pri code", 64'(feat_pri_code), 64'd4);

      // all-ones write: only bits 1 and 0 take effect
      wr(2'd0, 1'b0, '1);
      rd(2'd0, 1'b0, r); chk("R1 R2 R3 R4 ctl after all-ones", r, CTL_BASE | 64'd3);
      chk("R5 eoi_deact low", 64'(eoi_deact), 64'd0);
      chk("R6 cbp_on high", 64'(cbp_on), 64'd1);
      chk("R2 feature after write", 64'({feat_ext_range, feat_range_sel, feat_aff3, feat_sei}), 64'b1010);
      wr(2'd0, 1'b1, 64'd2);
      rd(2'd0, 1'b1, r); chk("R5 eoi only", r, CTL_BASE | 64'd2);
      chk("R5 eoi_deact low again", 64'(eoi_deact), 64'd0);
      wr(2'd0, 1'b0, 64'd0);
      rd(2'd0, 1'b0, r); chk("R5 cleared", r, CTL_BASE);
      chk("R5 eoi_deact high", 64'(eoi_deact), 64'd1);

      // R6 R11 independent registers with common bit clear
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 8; v++) begin
            wr(2'd1, s[0], 64'(v ^ 5));
            wr(2'd2, s[0], 64'hFFFF_FFFF_FFFF_FFF8 | 64'(v));
            rd(2'd2, s[0], r); chk("R6 R11 bp1 direct", r, 64'(v));
            rd(2'd1, ~s[0], r); chk("R6 R11 bp0 kept", r, 64'(v ^ 5));
         end
      end
      last_bp1 = 7;

      // common bit set
      wr(2'd0, 1'b0, 64'd1);
      for (int v = 0; v < 8; v++) begin
         wr(2'd1, v[0], 64'(v));
         rd(2'd2, 1'b0, r); chk("R7 ns aliased read", r, sat1(v));
         rd(2'd2, 1'b1, r); chk("R9 s aliased read", r, 64'(v));
         wr(2'd2, 1'b0, 64'(v ^ 3));
         rd(2'd1, 1'b0, r); chk("R8 ns write ignored bp0", r, 64'(v));
         wr(2'd2, 1'b1, 64'(7 - v));
         rd(2'd1, 1'b0, r); chk("R9 s write to bp0", r, 64'(7 - v));
         rd(2'd2, 1'b0, r); chk("R7 ns read after s write", r, sat1(7 - v));
      end

      // R8: the own bp1 value was not touched while aliased
      wr(2'd0, 1'b0, 64'd0);
      rd(2'd2, 1'b0, r); chk("R8 bp1 untouched", r, 64'(last_bp1));
      rd(2'd1, 1'b1, r); chk("R11 bp0 after mode exit", r, 64'd0);

      // R1 select 3 write ignored
      wr(2'd3, 1'b1, '1);
      rd(2'd0, 1'b0, r); chk("R1 sel3 write ctl", r, CTL_BASE);
      rd(2'd1, 1'b0, r); chk("R1 sel3 write bp0", r, 64'd0);
      rd(2'd2, 1'b0, r); chk("R1 sel3 write bp1", r, 64'd7);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule